// File: doc/BRIEF.md
# Future-File Operand Lookup Unit

This unit sits in the decode stage of an out-of-order core and decides, for each of two source operands, whether the instruction can take a value right away or must wait for a producer identified by a reorder-buffer tag. It keeps three pieces of per-register state: a rename map (a pending flag plus the producer tag), a speculative future file (a value plus a valid flag), and the committed register file. All three are read in the same cycle as the decode. A pending rename entry wins. Otherwise a valid future-file value is used. Otherwise the committed value is used.

Each decoded instruction takes the next reorder-buffer slot, and that slot index is its tag. An instruction with a destination records its tag in the rename map for that register. When a result completes, the unit broadcasts it so that waiting entries can capture it. The future file is updated only when the completing tag is still the one the rename map expects for that register. A result from an older producer that has since been superseded is broadcast but does not touch the future file. A separate commit port writes the committed register file.

Top module: `ffu_operand_lookup`

## Requirements
- R1: After reset every rename entry and every future-file entry is clear, the allocation tag is 0, and committed register i holds 0xA000 + i, so every operand reads back ready with that value.
- R2: A source whose rename entry is pending is reported not ready, with the stored producer tag on its tag output and 0 on its value output.
- R3: A source that is not pending takes the future-file value when that entry is valid, and the committed value when it is not. A ready operand shows tag 0.
- R4: The allocation tag advances by one for each cycle with a decode and wraps from ROB_DEPTH-1 (7) to 0. It holds when there is no decode.
- R5: A decode with a destination marks that register pending under the allocation tag of that cycle. Sources of the same decode still see the mapping from before it. A decode without a destination changes no rename entry.
- R6: A write-back whose tag equals the pending tag of its destination register writes the value to the future file, clears the pending flag, and raises ff_hit in that cycle.
- R7: A write-back whose tag does not match, or whose register is not pending, leaves the rename map and the future file unchanged and keeps ff_hit low.
- R8: When a decode writes the same register as a matching write-back in the same cycle, the future file takes the result and the register stays pending under the new decode tag.
- R9: A source that is pending on the tag being written back in the same cycle is reported ready with the write-back value.
- R10: While wb_valid is high, the broadcast outputs carry the write-back tag and value with bcast_valid high. Otherwise bcast_valid is low.
- R11: A commit write updates the committed register file. The new value is visible from the next cycle only for a register that is neither pending nor valid in the future file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| dec_src_a | input | 2 | First source register |
| dec_src_b | input | 2 | Second source register |
| dec_has_dst | input | 1 | The decoded instruction writes a register |
| dec_dst | input | 2 | Destination register |
| dec_tag | output | 3 | Slot and tag allocated to this decode |
| opa_ready | output | 1 | First operand value is available |
| opa_tag | output | 3 | Producer tag of first operand when not ready |
| opa_value | output | 16 | First operand value when ready |
| opb_ready | output | 1 | Second operand value is available |
| opb_tag | output | 3 | Producer tag of second operand when not ready |
| opb_value | output | 16 | Second operand value when ready |
| wb_valid | input | 1 | A result completes this cycle |
| wb_tag | input | 3 | Tag of the completing instruction |
| wb_dst | input | 2 | Register the completing instruction writes |
| wb_value | input | 16 | Result value |
| cm_valid | input | 1 | Commit write to the committed register file |
| cm_reg | input | 2 | Committed register index |
| cm_value | input | 16 | Committed value |
| ff_hit | output | 1 | The write-back updated the future file |
| bcast_valid | output | 1 | Result broadcast is valid |
| bcast_tag | output | 3 | Broadcast tag |
| bcast_value | output | 16 | Broadcast value |

## Verification
The hardest situation to reach from the ports is a stale write-back. This is a result whose producer was renamed over before it completed. It has to be separated both from a matching write-back and from a write-back that meets a decode to the same register in the same cycle. The stimulus reaches these by writing one register twice and completing the older tag, and then by completing a tag while a new decode to that register is in progress. A long pseudo-random phase then mixes matching and non-matching tags, decodes, commits and same-cycle bypasses against an arithmetic model of the three state arrays.

// File: rtl/ffu_pkg.sv
package ffu_pkg;
    localparam int NREG      = 4;
    localparam int RW        = $clog2(NREG);
    localparam int ROB_DEPTH = 8;
    localparam int TW        = $clog2(ROB_DEPTH);
    localparam int DW        = 16;
    localparam int NSRC      = 2;

    typedef logic [RW-1:0] areg_t;
    typedef logic [TW-1:0] tag_t;
    typedef logic [DW-1:0] data_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
    } rmap_t;

    typedef struct packed {
        logic  ready;
        tag_t  tag;
        data_t value;
    } opnd_t;

    localparam tag_t TAG_LAST = tag_t'(ROB_DEPTH - 1);

    function automatic data_t rf_reset_val(input int idx);
        return data_t'(32'hA000 + idx);
    endfunction

    function automatic tag_t tag_next(input tag_t t);
        return (t == TAG_LAST) ? '0 : t + tag_t'(1);
    endfunction
endpackage

// File: rtl/ffu_rename_table.sv
module ffu_rename_table
    import ffu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dec_we,
    input  areg_t                dec_reg,
    input  tag_t                 dec_tag,
    input  logic                 wb_valid,
    input  areg_t                wb_reg,
    input  tag_t                 wb_tag,
    output rmap_t [NREG-1:0]     map_q,
    output logic                 wb_match
);
    // a completion counts only if its producer is still the newest one
    assign wb_match = wb_valid && map_q[wb_reg].valid && (map_q[wb_reg].tag == wb_tag);

    for (genvar r = 0; r < NREG; r++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[r] <= '0;
            end else if (dec_we && dec_reg == areg_t'(r)) begin
                // new producer overrides a same-cycle completion
                map_q[r].valid <= 1'b1;
                map_q[r].tag   <= dec_tag;
            end else if (wb_match && wb_reg == areg_t'(r)) begin
                map_q[r].valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ffu_value_file.sv
module ffu_value_file
    import ffu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ff_we,
    input  areg_t                ff_reg,
    input  data_t                ff_wdata,
    input  logic                 cm_we,
    input  areg_t                cm_reg,
    input  data_t                cm_wdata,
    output logic  [NREG-1:0]     ff_valid,
    output data_t [NREG-1:0]     ff_data,
    output data_t [NREG-1:0]     rf_data
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                ff_valid[r] <= 1'b0;
                ff_data[r]  <= '0;
            end else if (ff_we && ff_reg == areg_t'(r)) begin
                ff_valid[r] <= 1'b1;
                ff_data[r]  <= ff_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rf_data[r] <= rf_reset_val(r);
            end else if (cm_we && cm_reg == areg_t'(r)) begin
                rf_data[r] <= cm_wdata;
            end
        end
    end
endmodule

// File: rtl/ffu_src_resolve.sv
module ffu_src_resolve
    import ffu_pkg::*;
(
    input  areg_t                src,
    input  rmap_t [NREG-1:0]     map_q,
    input  logic  [NREG-1:0]     ff_valid,
    input  data_t [NREG-1:0]     ff_data,
    input  data_t [NREG-1:0]     rf_data,
    input  logic                 wb_match,
    input  areg_t                wb_reg,
    input  data_t                wb_value,
    output opnd_t                opnd
);
    always_comb begin
        opnd = '0;
        if (map_q[src].valid) begin
            if (wb_match && wb_reg == src) begin
                opnd.ready = 1'b1;
                opnd.value = wb_value;
            end else begin
                opnd.ready = 1'b0;
                opnd.tag   = map_q[src].tag;
            end
        end else if (ff_valid[src]) begin
            opnd.ready = 1'b1;
            opnd.value = ff_data[src];
        end else begin
            opnd.ready = 1'b1;
            opnd.value = rf_data[src];
        end
    end
endmodule

// File: rtl/ffu_operand_lookup.sv
module ffu_operand_lookup
    import ffu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [RW-1:0]     dec_src_a,
    input  logic [RW-1:0]     dec_src_b,
    input  logic              dec_has_dst,
    input  logic [RW-1:0]     dec_dst,
    output logic [TW-1:0]     dec_tag,
    output logic              opa_ready,
    output logic [TW-1:0]     opa_tag,
    output logic [DW-1:0]     opa_value,
    output logic              opb_ready,
    output logic [TW-1:0]     opb_tag,
    output logic [DW-1:0]     opb_value,
    input  logic              wb_valid,
    input  logic [TW-1:0]     wb_tag,
    input  logic [RW-1:0]     wb_dst,
    input  logic [DW-1:0]     wb_value,
    input  logic              cm_valid,
    input  logic [RW-1:0]     cm_reg,
    input  logic [DW-1:0]     cm_value,
    output logic              ff_hit,
    output logic              bcast_valid,
    output logic [TW-1:0]     bcast_tag,
    output logic [DW-1:0]     bcast_value
);
    tag_t                 tail_q;
    rmap_t [NREG-1:0]     rmap;
    logic                 wb_match;
    logic  [NREG-1:0]     ff_vld;
    data_t [NREG-1:0]     ff_dat;
    data_t [NREG-1:0]     rf_dat;
    areg_t [NSRC-1:0]     srcs;
    opnd_t [NSRC-1:0]     opnd;

    always_ff @(posedge clk) begin
        if (rst)            tail_q <= '0;
        else if (dec_valid) tail_q <= tag_next(tail_q);
    end

    assign dec_tag = tail_q;

    ffu_rename_table u_rn (
        .clk      (clk),
        .rst      (rst),
        .dec_we   (dec_valid && dec_has_dst),
        .dec_reg  (dec_dst),
        .dec_tag  (tail_q),
        .wb_valid (wb_valid),
        .wb_reg   (wb_dst),
        .wb_tag   (wb_tag),
        .map_q    (rmap),
        .wb_match (wb_match)
    );

    ffu_value_file u_vf (
        .clk      (clk),
        .rst      (rst),
        .ff_we    (wb_match),
        .ff_reg   (wb_dst),
        .ff_wdata (wb_value),
        .cm_we    (cm_valid),
        .cm_reg   (cm_reg),
        .cm_wdata (cm_value),
        .ff_valid (ff_vld),
        .ff_data  (ff_dat),
        .rf_data  (rf_dat)
    );

    assign srcs[0] = dec_src_a;
    assign srcs[1] = dec_src_b;

    for (genvar p = 0; p < NSRC; p++) begin : g_src
        ffu_src_resolve u_res (
            .src      (srcs[p]),
            .map_q    (rmap),
            .ff_valid (ff_vld),
            .ff_data  (ff_dat),
            .rf_data  (rf_dat),
            .wb_match (wb_match),
            .wb_reg   (wb_dst),
            .wb_value (wb_value),
            .opnd     (opnd[p])
        );
    end

    assign opa_ready   = opnd[0].ready;
    assign opa_tag     = opnd[0].tag;
    assign opa_value   = opnd[0].value;
    assign opb_ready   = opnd[1].ready;
    assign opb_tag     = opnd[1].tag;
    assign opb_value   = opnd[1].value;

    assign ff_hit      = wb_match;
    assign bcast_valid = wb_valid;
    assign bcast_tag   = wb_tag;
    assign bcast_value = wb_value;
endmodule

// File: rtl/ffu_lookup_chk.sv
module ffu_lookup_chk
    import ffu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic              dec_has_dst,
    input areg_t             dec_dst,
    input areg_t             dec_src_a,
    input tag_t              dec_tag,
    input logic              opa_ready,
    input logic              wb_valid,
    input areg_t             wb_dst,
    input logic              ff_hit,
    input logic              bcast_valid,
    input rmap_t [NREG-1:0]  rmap
);
    // R1
    reset_tag_chk: assert property (@(posedge clk) rst |=> dec_tag == '0);

    // R4
    tag_step_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> dec_tag == tag_next($past(dec_tag)));

    // R4
    tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> $stable(dec_tag));

    // R5
    dst_map_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_has_dst) |=>
            (rmap[$past(dec_dst)].valid && rmap[$past(dec_dst)].tag == $past(dec_tag)));

    // R2
    pending_src_chk: assert property (@(posedge clk) disable iff (rst)
        !opa_ready |-> rmap[dec_src_a].valid);

    // R6
    hit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ff_hit && !(dec_valid && dec_has_dst && dec_dst == wb_dst)) |=>
            !rmap[$past(wb_dst)].valid);

    // R7
    stale_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !ff_hit && !(dec_valid && dec_has_dst)) |=> rmap == $past(rmap));

    // R10
    hit_bcast_chk: assert property (@(posedge clk) disable iff (rst)
        ff_hit |-> bcast_valid);
endmodule

bind ffu_operand_lookup ffu_lookup_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .dec_has_dst (dec_has_dst),
    .dec_dst     (dec_dst),
    .dec_src_a   (dec_src_a),
    .dec_tag     (dec_tag),
    .opa_ready   (opa_ready),
    .wb_valid    (wb_valid),
    .wb_dst      (wb_dst),
    .ff_hit      (ff_hit),
    .bcast_valid (bcast_valid),
    .rmap        (rmap)
);

// File: tb/sim_ffu_operand_lookup.sv
`timescale 1ns/1ps
module sim_ffu_operand_lookup;
    localparam int NR = 4;
    localparam int TD = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid, dec_has_dst;
    logic [1:0]  dec_src_a, dec_src_b, dec_dst;
    logic [2:0]  dec_tag;
    logic        opa_ready, opb_ready;
    logic [2:0]  opa_tag, opb_tag;
    logic [15:0] opa_value, opb_value;
    logic        wb_valid;
    logic [2:0]  wb_tag;
    logic [1:0]  wb_dst;
    logic [15:0] wb_value;
    logic        cm_valid;
    logic [1:0]  cm_reg;
    logic [15:0] cm_value;
    logic        ff_hit, bcast_valid;
    logic [2:0]  bcast_tag;
    logic [15:0] bcast_value;

    always #2.5 clk = ~clk;

    ffu_operand_lookup u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    bit          mv   [NR];
    logic [2:0]  mt   [NR];
    bit          mfv  [NR];
    logic [15:0] mff  [NR];
    logic [15:0] mrf  [NR];
    logic [2:0]  mtail;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin
            mv[i] = 0; mt[i] = '0; mfv[i] = 0; mff[i] = '0;
            mrf[i] = 16'hA000 + 16'(i);
        end
        mtail = '0;
    endtask

    function automatic bit wmatch_f();
        return wb_valid && mv[wb_dst] && (mt[wb_dst] == wb_tag);
    endfunction

    // expected {ready, tag, value} and the requirement that governs it
    function automatic logic [19:0] exp_op(input logic [1:0] s, output string req);
        if (mv[s]) begin
            if (wmatch_f() && wb_dst == s) begin req = "R9"; return {1'b1, 3'd0, wb_value}; end
            req = "R2"; return {1'b0, mt[s], 16'h0};
        end
        req = mfv[s] ? "R3" : "R11";
        return {1'b1, 3'd0, mfv[s] ? mff[s] : mrf[s]};
    endfunction

    task automatic drive(input bit dv, input logic [1:0] sa, input logic [1:0] sb, input bit hd,
                         input logic [1:0] dd, input bit wv, input logic [2:0] wt,
                         input logic [1:0] wd, input logic [15:0] wval,
                         input bit cv, input logic [1:0] cr, input logic [15:0] cval);
        dec_valid = dv; dec_src_a = sa; dec_src_b = sb; dec_has_dst = hd; dec_dst = dd;
        wb_valid = wv; wb_tag = wt; wb_dst = wd; wb_value = wval;
        cm_valid = cv; cm_reg = cr; cm_value = cval;
    endtask

    // one cycle: check outputs against the model, then advance the model at the edge
    task automatic step(input bit dv, input logic [1:0] sa, input logic [1:0] sb, input bit hd,
                        input logic [1:0] dd, input bit wv, input logic [2:0] wt,
                        input logic [1:0] wd, input logic [15:0] wval,
                        input bit cv, input logic [1:0] cr, input logic [15:0] cval);
        logic [19:0] ea, eb;
        string ra, rb;
        bit wm;
        drive(dv, sa, sb, hd, dd, wv, wt, wd, wval, cv, cr, cval);
        #1;
        ea = exp_op(sa, ra);
        eb = exp_op(sb, rb);
        wm = wmatch_f();
        check({opa_ready, opa_tag, opa_value} == ea, ra, 32'({opa_ready, opa_tag, opa_value}), 32'(ea));
        check({opb_ready, opb_tag, opb_value} == eb, rb, 32'({opb_ready, opb_tag, opb_value}), 32'(eb));
        check(dec_tag == mtail, "R4", 32'(dec_tag), 32'(mtail));
        check(ff_hit == wm, wm ? "R6" : "R7", 32'(ff_hit), 32'(wm));
        check(bcast_valid == wv && (!wv || (bcast_tag == wt && bcast_value == wval)), "R10",
              32'({bcast_valid, bcast_tag, bcast_value}), 32'({wv, wt, wval}));
        @(posedge clk);
        if (wm) begin mfv[wd] = 1; mff[wd] = wval; mv[wd] = 0; end
        if (dv && hd) begin mv[dd] = 1; mt[dd] = mtail; end
        if (cv) mrf[cr] = cval;
        if (dv) mtail = (mtail == 3'(TD - 1)) ? 3'd0 : mtail + 3'd1;
        #1;
    endtask

    // read-only cycle with hand-computed expectation on operand A
    task automatic probe(input logic [1:0] s, input logic [19:0] exp, input string req);
        drive(0, s, s, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        check({opa_ready, opa_tag, opa_value} == exp, req, 32'({opa_ready, opa_tag, opa_value}), 32'(exp));
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();

        // R1: reset state reads committed reset values
        probe(2'd0, {1'b1, 3'd0, 16'hA000}, "R1");
        probe(2'd3, {1'b1, 3'd0, 16'hA003}, "R1");
        check(dec_tag == 3'd0, "R1", 32'(dec_tag), 0);

        // R5: decode dst 2 reading 2 itself sees the old mapping (tag 0)
        step(1, 2'd2, 2'd3, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0);
        probe(2'd2, {1'b0, 3'd0, 16'h0}, "R5");
        // R7: stale tag 5 for register 2
        step(0, 2'd2, 2'd1, 0, 0, 1, 3'd5, 2'd2, 16'h1234, 0, 0, 0);
        probe(2'd2, {1'b0, 3'd0, 16'h0}, "R7");
        // R9 and R6: matching completion bypassed to a same-cycle reader
        step(0, 2'd2, 2'd2, 0, 0, 1, 3'd0, 2'd2, 16'h5555, 0, 0, 0);
        probe(2'd2, {1'b1, 3'd0, 16'h5555}, "R6");
        // R3 / R11: commit hidden by future file on reg 2, visible on reg 3
        step(0, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'h7777);
        probe(2'd2, {1'b1, 3'd0, 16'h5555}, "R3");
        step(0, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 1, 2'd3, 16'h3333);
        probe(2'd3, {1'b1, 3'd0, 16'h3333}, "R11");
        // R8: reg 1 gets tag 1, then decode to reg 1 (tag 2) meets completion of tag 1
        step(1, 2'd0, 2'd0, 1, 2'd1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 2'd0, 2'd0, 1, 2'd1, 1, 3'd1, 2'd1, 16'h9999, 0, 0, 0);
        probe(2'd1, {1'b0, 3'd2, 16'h0}, "R8");
        // R5: decode without destination leaves reg 0 untouched
        step(1, 2'd0, 2'd0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
        probe(2'd0, {1'b1, 3'd0, 16'hA000}, "R5");
        // R4: walk the tag through its wrap point
        for (int i = 0; i < 10; i++) step(1, 2'd0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // mixed sweep
        seed = 32'h1d2c3b4a;
        for (int i = 0; i < 4000; i++) begin
            bit dv, hd, wv, cv;
            logic [1:0] sa, sb, dd, wd, cr;
            logic [2:0] wt;
            logic [15:0] wval, cval;
            seed = seed * 1103515245 + 12345;
            dv = seed[31]; hd = seed[30]; sa = seed[29:28]; sb = seed[27:26]; dd = seed[25:24];
            wv = seed[23]; wd = seed[22:21]; cv = (seed[20:18] == 3'd0); cr = seed[17:16];
            wt = (seed[15] && mv[wd]) ? mt[wd] : seed[14:12];
            seed = seed * 1103515245 + 12345;
            wval = seed[31:16]; cval = seed[15:0];
            step(dv, sa, sb, hd, dd, wv, wt, wd, wval, cv, cr, cval);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule